// File: doc/BRIEF.md
# Row Readout Sequencer for an Active-Matrix Pixel Array

This block runs the readout of an active-matrix X-ray pixel sensor. Each frame starts on a rising edge of an external timing input. The sequencer then waits a programmed delay and holds an integration-window output for a programmed length. After that it switches the array on one row at a time. While a row is on, the sequencer steps the front-end column multiplexer through its positions. At the end of each multiplexer slot it captures every channel of the parallel ADC bank at once. It then sends the captured samples out as a stream of beats. Each beat holds one ADC's channels and is tagged with its row, its first column, a start-of-frame flag and an end-of-row flag.

Software sets four registers through a simple write port: a gain code that goes straight to the analog front end, the trigger-to-window delay, the window length, and the guard gap between rows. The row timing is fixed and never waits on the consumer of the stream. If the consumer is not ready, the sequencer records an overflow instead of stalling. A trigger edge that arrives while a frame is still running is counted and otherwise ignored.

Top module: `rowReadSeq`

## Requirements
- R1: After reset, all of these outputs are low or zero: row enables, integration window, multiplexer select, stream valid, overflow, dropped-trigger count and gain code.
- R2: A write with `cfgWe` high stores `cfgWdata` in the register chosen by `cfgAddr`. The addresses are 0 = gain, 1 = delay, 2 = window, 3 = guard. The gain code appears on `gainSel` on the cycle after the write, and writes to the other addresses leave it unchanged.
- R3: After a trigger rising edge accepted while idle, `integWin` stays low for delay+1 cycles and then stays high for exactly window+1 cycles. No row enable is high while `integWin` is high.
- R4: On the cycle after the window ends, row 0 is enabled. The rows then follow in ascending order, with at most one enable high at any time. Each row stays enabled for exactly MUX_STEPS × SLOT_CYCLES cycles. All enables are low after the last row.
- R5: Between two consecutive rows, all row enables stay low for exactly guard+1 cycles.
- R6: While a row is enabled, `muxSel` holds value k for the k-th group of SLOT_CYCLES cycles, for k from 0 to MUX_STEPS−1. Outside a row, `muxSel` is 0.
- R7: In the last cycle of each multiplexer slot, all NUM_ADC × ADC_CH lanes of `adcData` are captured. Lane L occupies bits [L·SAMPLE_W +: SAMPLE_W] and carries column muxSel + MUX_STEPS·L. The capture then produces NUM_ADC beats, one per cycle, in ascending ADC index a. Beat a carries lanes a·ADC_CH to a·ADC_CH+ADC_CH−1, with channel 0 in the low bits. `outCol` is the column of that beat's channel 0, mux step + MUX_STEPS·ADC_CH·a, and `outRow` is the row being read.
- R8: `outSof` is high only on the first beat of row 0 (column 0). `outEor` is high only on the beat that holds the row's last column, which is the last beat of the final slot.
- R9: A trigger rising edge while a frame is running increments `dropCount`, which saturates at its maximum, and leaves the frame timing and the stream unchanged.
- R10: A cycle with `outValid` high and `outReady` low sets `overflow`. The beat is not held, and later beats keep their schedule. `overflow` stays set until the next accepted trigger clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select: 0 gain, 1 delay, 2 window, 3 guard |
| cfgWdata | input | CFG_W | Register write data |
| trigIn | input | 1 | Frame timing pulse; the rising edge starts a frame |
| gainSel | output | GAIN_W | Gain code to the front end |
| integWin | output | 1 | High during the integration window |
| rowEnable | output | NUM_ROWS | One-hot row switch enables |
| muxSel | output | MUX_W | Front-end column multiplexer select |
| adcData | input | NUM_ADC·ADC_CH·SAMPLE_W | All ADC channel samples, lane L at bits [L·SAMPLE_W +: SAMPLE_W] |
| outValid | output | 1 | Stream beat valid |
| outReady | input | 1 | Stream consumer ready |
| outData | output | ADC_CH·SAMPLE_W | One ADC's channels, channel 0 lowest |
| outRow | output | ROW_W | Row index of the beat |
| outCol | output | COL_W | Column of channel 0 of the beat |
| outSof | output | 1 | Start of frame |
| outEor | output | 1 | End of row |
| overflow | output | 1 | Sticky flag set by a beat offered while the consumer was not ready |
| dropCount | output | DROP_W | Saturating count of triggers ignored while busy |

## Verification
The bench builds the block with 3 rows, 4 multiplexer steps, 2 ADCs of 2 channels, 8-bit samples and 3-cycle slots. This gives a 16-column row that takes 12 cycles, so one frame lasts well under a hundred cycles. With these sizes the bench can run several full frames, with zero and non-zero delay, window and guard settings. It can place a trigger in the middle of a row and a one-cycle ready drop on a specific beat. It can also compare every beat of every frame against a column-derived sample pattern. The 2-ADC bank is enough to exercise the beat ordering across ADCs and the column stride between them, and the 4-step multiplexer is enough to check the end-of-row flag on the final slot.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_DELAY,
    SEQ_INTEG,
    SEQ_ROW,
    SEQ_GUARD
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic frameStart;  // trigger accepted, new frame begins
    logic capture;     // last cycle of a mux slot: latch all lanes
    logic rowZero;     // current row is row 0
    logic lastStep;    // current mux step is the final one
  } seqStrobe_t;

  localparam logic [1:0] CFG_GAIN   = 2'd0;
  localparam logic [1:0] CFG_DELAY  = 2'd1;
  localparam logic [1:0] CFG_WINDOW = 2'd2;
  localparam logic [1:0] CFG_GUARD  = 2'd3;

endpackage

// File: rtl/seqCfg.sv
module seqCfg
  import rowseq_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [GAIN_W-1:0] gainSel,
  output logic [CFG_W-1:0]  delayVal,
  output logic [CFG_W-1:0]  windowVal,
  output logic [CFG_W-1:0]  guardVal
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainSel   <= '0;
      delayVal  <= '0;
      windowVal <= '0;
      guardVal  <= '0;
    end else if (cfgWe) begin
      unique case (cfgAddr)
        CFG_GAIN:   gainSel   <= cfgWdata[GAIN_W-1:0];
        CFG_DELAY:  delayVal  <= cfgWdata;
        CFG_WINDOW: windowVal <= cfgWdata;
        CFG_GUARD:  guardVal  <= cfgWdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS    = 1024,
  parameter int MUX_STEPS   = 16,
  parameter int SLOT_CYCLES = 8,
  parameter int CFG_W       = 16,
  parameter int DROP_W      = 8,
  localparam int ROW_W      = $clog2(NUM_ROWS),
  localparam int MUX_W      = $clog2(MUX_STEPS),
  localparam int SLOT_W     = $clog2(SLOT_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigIn,
  input  logic [CFG_W-1:0]    delayVal,
  input  logic [CFG_W-1:0]    windowVal,
  input  logic [CFG_W-1:0]    guardVal,
  output logic                integWin,
  output logic [NUM_ROWS-1:0] rowEnable,
  output logic [MUX_W-1:0]    muxSel,
  output logic [ROW_W-1:0]    rowIdx,
  output logic [DROP_W-1:0]   dropCount,
  output seqStrobe_t          strb
);

  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(NUM_ROWS - 1);
  localparam logic [MUX_W-1:0]  MUX_LAST  = MUX_W'(MUX_STEPS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);

  seqState_t         state;
  logic              trigPrev;
  logic              trigEdge;
  logic [CFG_W-1:0]  cnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [MUX_W-1:0]  muxStep;
  logic              rowOn;

  assign trigEdge = trigIn && !trigPrev;
  assign rowOn    = (state == SEQ_ROW);
  assign integWin = (state == SEQ_INTEG);
  assign muxSel   = muxStep;

  assign strb.frameStart = trigEdge && (state == SEQ_IDLE);
  assign strb.capture    = rowOn && (slotCnt == SLOT_LAST);
  assign strb.rowZero    = (rowIdx == '0);
  assign strb.lastStep   = (muxStep == MUX_LAST);

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_rowDec
    assign rowEnable[g] = rowOn && (rowIdx == ROW_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      trigPrev  <= 1'b0;
      cnt       <= '0;
      slotCnt   <= '0;
      muxStep   <= '0;
      rowIdx    <= '0;
      dropCount <= '0;
    end else begin
      trigPrev <= trigIn;
      if (trigEdge && (state != SEQ_IDLE) && (dropCount != '1))
        dropCount <= dropCount + 1'b1;

      unique case (state)
        SEQ_IDLE: begin
          if (trigEdge) begin
            state <= SEQ_DELAY;
            cnt   <= delayVal;
          end
        end
        SEQ_DELAY: begin
          if (cnt == '0) begin
            state <= SEQ_INTEG;
            cnt   <= windowVal;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_INTEG: begin
          if (cnt == '0) begin
            state   <= SEQ_ROW;
            rowIdx  <= '0;
            muxStep <= '0;
            slotCnt <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_ROW: begin
          if (slotCnt == SLOT_LAST) begin
            slotCnt <= '0;
            if (muxStep == MUX_LAST) begin
              muxStep <= '0;
              if (rowIdx == ROW_LAST) begin
                state <= SEQ_IDLE;
              end else begin
                state <= SEQ_GUARD;
                cnt   <= guardVal;
              end
            end else begin
              muxStep <= muxStep + 1'b1;
            end
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
        SEQ_GUARD: begin
          if (cnt == '0) begin
            state  <= SEQ_ROW;
            rowIdx <= rowIdx + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seqData.sv
module seqData
  import rowseq_pkg::*;
#(
  parameter int NUM_ADC    = 8,
  parameter int ADC_CH     = 8,
  parameter int SAMPLE_W   = 12,
  parameter int MUX_STEPS  = 16,
  parameter int ROW_W      = 10,
  parameter int MUX_W      = 4,
  parameter int COL_W      = 10,
  localparam int BEAT_W    = ADC_CH * SAMPLE_W,
  localparam int LANE_BITS = NUM_ADC * BEAT_W,
  localparam int BI_W      = (NUM_ADC > 1) ? $clog2(NUM_ADC) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strb,
  input  logic [ROW_W-1:0]     rowIdx,
  input  logic [MUX_W-1:0]     muxStep,
  input  logic [LANE_BITS-1:0] adcData,
  input  logic                 outReady,
  output logic                 outValid,
  output logic [BEAT_W-1:0]    outData,
  output logic [ROW_W-1:0]     outRow,
  output logic [COL_W-1:0]     outCol,
  output logic                 outSof,
  output logic                 outEor,
  output logic                 overflow
);

  localparam logic [BI_W-1:0]  BEAT_LAST = BI_W'(NUM_ADC - 1);
  localparam logic [COL_W-1:0] COL_STEP  = COL_W'(MUX_STEPS * ADC_CH);

  logic [NUM_ADC-1:0][BEAT_W-1:0] shadow;
  logic [ROW_W-1:0] tagRow;
  logic [MUX_W-1:0] tagStep;
  logic             tagSof;
  logic             tagEor;
  logic             pending;
  logic [BI_W-1:0]  beatIdx;

  // capture bank and beat pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow  <= '0;
      tagRow  <= '0;
      tagStep <= '0;
      tagSof  <= 1'b0;
      tagEor  <= 1'b0;
      pending <= 1'b0;
      beatIdx <= '0;
    end else if (strb.capture) begin
      shadow  <= adcData;
      tagRow  <= rowIdx;
      tagStep <= muxStep;
      tagSof  <= strb.rowZero && (muxStep == '0);
      tagEor  <= strb.lastStep;
      pending <= 1'b1;
      beatIdx <= '0;
    end else if (pending) begin
      if (beatIdx == BEAT_LAST) pending <= 1'b0;
      beatIdx <= beatIdx + 1'b1;
    end
  end

  // registered stream output, never stalled
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outRow   <= '0;
      outCol   <= '0;
      outSof   <= 1'b0;
      outEor   <= 1'b0;
    end else begin
      outValid <= pending;
      outSof   <= pending && tagSof && (beatIdx == '0);
      outEor   <= pending && tagEor && (beatIdx == BEAT_LAST);
      if (pending) begin
        outData <= shadow[beatIdx];
        outRow  <= tagRow;
        outCol  <= COL_W'(tagStep) + COL_W'(beatIdx) * COL_STEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      overflow <= 1'b0;
    else if (outValid && !outReady) overflow <= 1'b1;
    else if (strb.frameStart)       overflow <= 1'b0;
  end

endmodule

// File: rtl/rowReadSeq.sv
module rowReadSeq
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS    = 1024,
  parameter int MUX_STEPS   = 16,
  parameter int NUM_ADC     = 8,
  parameter int ADC_CH      = 8,
  parameter int SAMPLE_W    = 12,
  parameter int SLOT_CYCLES = 8,
  parameter int CFG_W       = 16,
  parameter int GAIN_W      = 3,
  parameter int DROP_W      = 8,
  localparam int ROW_W      = $clog2(NUM_ROWS),
  localparam int MUX_W      = $clog2(MUX_STEPS),
  localparam int COL_W      = $clog2(MUX_STEPS * NUM_ADC * ADC_CH),
  localparam int BEAT_W     = ADC_CH * SAMPLE_W,
  localparam int LANE_BITS  = NUM_ADC * BEAT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [1:0]           cfgAddr,
  input  logic [CFG_W-1:0]     cfgWdata,
  input  logic                 trigIn,
  output logic [GAIN_W-1:0]    gainSel,
  output logic                 integWin,
  output logic [NUM_ROWS-1:0]  rowEnable,
  output logic [MUX_W-1:0]     muxSel,
  input  logic [LANE_BITS-1:0] adcData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [BEAT_W-1:0]    outData,
  output logic [ROW_W-1:0]     outRow,
  output logic [COL_W-1:0]     outCol,
  output logic                 outSof,
  output logic                 outEor,
  output logic                 overflow,
  output logic [DROP_W-1:0]    dropCount
);

  logic [CFG_W-1:0] delayVal;
  logic [CFG_W-1:0] windowVal;
  logic [CFG_W-1:0] guardVal;
  logic [ROW_W-1:0] rowIdx;
  seqStrobe_t       strb;

  seqCfg #(.CFG_W(CFG_W), .GAIN_W(GAIN_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .gainSel(gainSel), .delayVal(delayVal),
    .windowVal(windowVal), .guardVal(guardVal)
  );

  seqCtrl #(
    .NUM_ROWS(NUM_ROWS), .MUX_STEPS(MUX_STEPS), .SLOT_CYCLES(SLOT_CYCLES),
    .CFG_W(CFG_W), .DROP_W(DROP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .delayVal(delayVal),
    .windowVal(windowVal), .guardVal(guardVal), .integWin(integWin),
    .rowEnable(rowEnable), .muxSel(muxSel), .rowIdx(rowIdx),
    .dropCount(dropCount), .strb(strb)
  );

  seqData #(
    .NUM_ADC(NUM_ADC), .ADC_CH(ADC_CH), .SAMPLE_W(SAMPLE_W),
    .MUX_STEPS(MUX_STEPS), .ROW_W(ROW_W), .MUX_W(MUX_W), .COL_W(COL_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rowIdx(rowIdx), .muxStep(muxSel),
    .adcData(adcData), .outReady(outReady), .outValid(outValid),
    .outData(outData), .outRow(outRow), .outCol(outCol), .outSof(outSof),
    .outEor(outEor), .overflow(overflow)
  );

endmodule

// File: rtl/rowReadSeq_chk.sv
module rowReadSeq_chk #(
  parameter int NUM_ROWS = 4,
  parameter int MUX_W    = 2,
  parameter int COL_W    = 4,
  parameter int DROP_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                trigIn,
  input logic                integWin,
  input logic [NUM_ROWS-1:0] rowEnable,
  input logic [MUX_W-1:0]    muxSel,
  input logic                outValid,
  input logic                outReady,
  input logic                outSof,
  input logic [COL_W-1:0]    outCol,
  input logic                overflow,
  input logic [DROP_W-1:0]   dropCount
);

  // R4
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowEnable));

  // R3
  integ_no_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    integWin |-> (rowEnable == '0));

  // R6
  mux_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (muxSel != '0) |-> (rowEnable != '0));

  // R8
  sof_first_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> (outValid && (outCol == '0)));

  // R10
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(outValid && !outReady));

  // R9
  drop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |-> (dropCount == $past(dropCount) + 1'b1));

  // R9
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |-> $past(trigIn));

endmodule

bind rowReadSeq rowReadSeq_chk #(
  .NUM_ROWS(NUM_ROWS), .MUX_W(MUX_W), .COL_W(COL_W), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .integWin(integWin),
  .rowEnable(rowEnable), .muxSel(muxSel), .outValid(outValid),
  .outReady(outReady), .outSof(outSof), .outCol(outCol),
  .overflow(overflow), .dropCount(dropCount)
);

// File: tb/rowReadSeq_tb.sv
module rowReadSeq_tb;

  localparam int NR   = 3;
  localparam int MUX  = 4;
  localparam int NADC = 2;
  localparam int CH   = 2;
  localparam int SW   = 8;
  localparam int SLOT = 3;
  localparam int CW   = 8;
  localparam int GW   = 3;
  localparam int DW   = 4;
  localparam int ROW_W  = $clog2(NR);
  localparam int MUX_W  = $clog2(MUX);
  localparam int COL_W  = $clog2(MUX * NADC * CH);
  localparam int BEAT_W = CH * SW;
  localparam int LANES  = NADC * CH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [CW-1:0] cfgWdata = '0;
  logic trigIn = 1'b0;
  logic outReady = 1'b1;
  logic [GW-1:0] gainSel;
  logic integWin;
  logic [NR-1:0] rowEnable;
  logic [MUX_W-1:0] muxSel;
  logic [LANES*SW-1:0] adcData;
  logic outValid, outSof, outEor, overflow;
  logic [BEAT_W-1:0] outData;
  logic [ROW_W-1:0] outRow;
  logic [COL_W-1:0] outCol;
  logic [DW-1:0] dropCount;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rowReadSeq #(
    .NUM_ROWS(NR), .MUX_STEPS(MUX), .NUM_ADC(NADC), .ADC_CH(CH),
    .SAMPLE_W(SW), .SLOT_CYCLES(SLOT), .CFG_W(CW), .GAIN_W(GW), .DROP_W(DW)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .trigIn(trigIn), .gainSel(gainSel),
    .integWin(integWin), .rowEnable(rowEnable), .muxSel(muxSel),
    .adcData(adcData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outRow(outRow), .outCol(outCol), .outSof(outSof),
    .outEor(outEor), .overflow(overflow), .dropCount(dropCount)
  );

  function automatic logic [SW-1:0] sampleVal(int r, int c);
    return SW'((r * 29 + c * 7 + 3) % 256);
  endfunction

  // sensor + ADC model: lane L sees column muxSel + MUX*L of the enabled row
  always_comb begin
    int curRow;
    curRow = 0;
    for (int i = 0; i < NR; i++) if (rowEnable[i]) curRow = i;
    for (int l = 0; l < LANES; l++)
      adcData[l*SW +: SW] = sampleVal(curRow, int'(muxSel) + MUX * l);
  end

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic              sof;
    logic              eor;
  } beat_t;

  beat_t expQ[$];

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pushFrame();
    for (int r = 0; r < NR; r++)
      for (int s = 0; s < MUX; s++)
        for (int a = 0; a < NADC; a++) begin
          beat_t b;
          for (int c = 0; c < CH; c++)
            b.data[c*SW +: SW] = sampleVal(r, s + MUX * (a * CH + c));
          b.row = ROW_W'(r);
          b.col = COL_W'(s + MUX * CH * a);
          b.sof = (r == 0) && (s == 0) && (a == 0);
          b.eor = (s == MUX - 1) && (a == NADC - 1);
          expQ.push_back(b);
        end
  endtask

  // monitor: every offered beat is compared, ready or not (timing never stalls)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        chk("R7 unexpected beat", 1'b0, outCol, 0);
      end else begin
        beat_t e;
        e = expQ.pop_front();
        chk("R7 data", outData == e.data, outData, e.data);
        chk("R7 column", outCol == e.col, outCol, e.col);
        chk("R7 row", outRow == e.row, outRow, e.row);
        chk("R8 sof", outSof == e.sof, outSof, e.sof);
        chk("R8 eor", outEor == e.eor, outEor, e.eor);
      end
    end
  end

  task automatic cfgWrite(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runFrame(input int dly, input int win, input int grd,
                          input bit doDrop, input bit doStall);
    int gap, len, bad;
    cfgWrite(2'd1, CW'(dly));
    cfgWrite(2'd2, CW'(win));
    cfgWrite(2'd3, CW'(grd));
    pushFrame();
    @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
    gap = 0;
    while (!integWin && gap < 1000) begin gap++; @(negedge clk); end
    chk("R3 delay", gap == dly + 1, gap, dly + 1);
    len = 0;
    while (integWin && len < 1000) begin len++; @(negedge clk); end
    chk("R3 window", len == win + 1, len, win + 1);
    for (int r = 0; r < NR; r++) begin
      bad = 0;
      for (int c = 0; c < MUX * SLOT; c++) begin
        if (doDrop && r == 1) trigIn = (c == 0);
        if (doStall && r == 0) outReady = !(c == SLOT + 1);
        if (rowEnable != NR'(1 << r)) bad++;
        if (muxSel != MUX_W'(c / SLOT)) bad += 100;
        @(negedge clk);
      end
      trigIn = 1'b0;
      outReady = 1'b1;
      chk("R4 row enable", (bad % 100) == 0, bad % 100, 0);
      chk("R6 mux select", bad < 100, bad / 100, 0);
      if (r < NR - 1) begin
        gap = 0;
        while (rowEnable == '0 && gap < 1000) begin gap++; @(negedge clk); end
        chk("R5 guard", gap == grd + 1, gap, grd + 1);
      end
    end
    chk("R4 rows off", rowEnable == '0, rowEnable, 0);
    chk("R6 mux idle", muxSel == '0, muxSel, 0);
    repeat (NADC + 3) @(negedge clk);
    chk("R7 all beats", expQ.size() == 0, expQ.size(), 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk("watchdog", 1'b0, 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rows", rowEnable == '0, rowEnable, 0);
    chk("R1 integ", integWin == 1'b0, integWin, 0);
    chk("R1 mux", muxSel == '0, muxSel, 0);
    chk("R1 valid", outValid == 1'b0, outValid, 0);
    chk("R1 overflow", overflow == 1'b0, overflow, 0);
    chk("R1 drops", dropCount == '0, dropCount, 0);
    chk("R1 gain", gainSel == '0, gainSel, 0);
    rstN = 1'b1;

    cfgWrite(2'd0, CW'(5));
    chk("R2 gain write", gainSel == GW'(5), gainSel, 5);

    runFrame(3, 2, 1, 1'b0, 1'b0);
    chk("R10 no overflow", overflow == 1'b0, overflow, 0);
    chk("R9 no drops", dropCount == '0, dropCount, 0);

    runFrame(0, 0, 0, 1'b1, 1'b0);
    chk("R9 drop counted", dropCount == DW'(1), dropCount, 1);

    runFrame(2, 1, 2, 1'b0, 1'b1);
    chk("R10 overflow set", overflow == 1'b1, overflow, 1);

    runFrame(1, 1, 0, 1'b0, 1'b0);
    chk("R10 overflow cleared", overflow == 1'b0, overflow, 0);

    cfgWrite(2'd0, CW'(2));
    cfgWrite(2'd1, CW'(7));
    cfgWrite(2'd3, CW'(6));
    chk("R2 gain kept", gainSel == GW'(2), gainSel, 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule